// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath in which each instruction is spread over several clock cycles. It is a Moore machine with ten states. Every instruction passes through a shared fetch state and a shared decode state. From decode, the machine branches on the 6-bit opcode held in the instruction register into a short class-specific tail, then returns to fetch. As a result, the number of cycles per instruction depends on the instruction class: load takes 5, store 4, register-register (R-type) 4, branch 3 and jump 3.

In each state the block drives sixteen datapath control bits. These cover PC update, memory access, instruction register capture, register file write, ALU operand steering, ALU operation class and PC source. All outputs are a function of the current state only.

The states, numbered 0 to 9 and held in a 4-bit register, are:

| State | Role |
|---|---|
| FETCH (0) | Instruction fetch |
| DECODE (1) | Decode and register fetch |
| ADDR (2) | Memory address computation |
| MEMRD (3) | Memory read |
| LDWB (4) | Load write-back |
| MEMWR (5) | Memory write |
| EXEC (6) | R-type execute |
| RWB (7) | R-type write-back |
| BRANCH (8) | Branch completion |
| JUMP (9) | Jump completion |

The transitions are:

- FETCH always goes to DECODE.
- DECODE goes to ADDR for load or store, EXEC for R-type, BRANCH for branch, JUMP for jump, and back to FETCH for any other opcode.
- ADDR goes to MEMRD for load and to MEMWR for any other opcode.
- MEMRD goes to LDWB.
- EXEC goes to RWB.
- LDWB, MEMWR, RWB, BRANCH and JUMP each go to FETCH.

Top module: `mc_ctrl_fsm`

## Requirements

Two encodings are used throughout:

- ALU class `alu_op`: 00 means add, 01 means subtract, 10 means select by funct. The code 11 is never driven.
- `pc_src`: 00 selects the ALU result, 01 selects the registered branch target, 10 selects the jump target.

Any output not listed for a state is 0.

- R1: When `rst` is high at a rising edge, the machine is in FETCH after that edge. This holds from any state.
- R2: FETCH drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00. It is always followed by DECODE.
- R3: DECODE drives only `alu_b_sel`=11 and `alu_op`=00. No write strobe and no memory read is active there.
- R4: A load (opcode 100011) runs FETCH, DECODE, ADDR, MEMRD, LDWB, which is 5 cycles.
  - ADDR drives `alu_a_sel`=1 and `alu_b_sel`=10.
  - MEMRD drives `mem_rd`=1 and `addr_sel`=1.
  - LDWB drives `reg_wr`=1 and `mem_to_reg`=1.
- R5: A store (opcode 101011) runs FETCH, DECODE, ADDR, MEMWR, which is 4 cycles. MEMWR drives `mem_wr`=1 and `addr_sel`=1.
- R6: An R-type (opcode 000000) runs FETCH, DECODE, EXEC, RWB, which is 4 cycles.
  - EXEC drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10.
  - RWB drives `reg_wr`=1 and `reg_dst`=1.
- R7: A branch (opcode 000100) runs FETCH, DECODE, BRANCH, which is 3 cycles. BRANCH drives `pc_wr_cond`=1, `alu_a_sel`=1, `alu_op`=01 and `pc_src`=01.
- R8: A jump (opcode 000010) runs FETCH, DECODE, JUMP, which is 3 cycles. JUMP drives `pc_wr`=1 and `pc_src`=10.
- R9: Any other opcode seen in DECODE returns the machine to FETCH on the next cycle.
- R10: The opcode is read only in DECODE and ADDR. Its value in any other state has no effect on the state sequence.
- R11: The following are never active together:
  - `mem_wr`, `reg_wr` and a PC update (`pc_wr` or `pc_wr_cond`);
  - `mem_rd` and `mem_wr`;
  - `alu_op`=11 is never driven.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address source: 0 for PC, 1 for ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register capture |
| mem_to_reg | output | 1 | Register write data: 0 for ALU output, 1 for memory data |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination field: 0 for rt, 1 for rd |
| alu_a_sel | output | 1 | ALU A operand: 0 for PC, 1 for register A |
| alu_b_sel | output | 2 | ALU B operand: 00 for reg B, 01 for constant 4, 10 for immediate, 11 for shifted immediate |
| alu_op | output | 2 | ALU operation class |
| pc_src | output | 2 | PC next-value source |

## Verification

The bench builds the block with its default opcode parameters (the five codes listed above and a 6-bit field). This brings every dispatch arm within reach, and 111111 serves as an unlisted opcode.

While the machine sits in a state where the opcode must be ignored, the bench drives codes of other instruction classes. This exposes any extra dispatch point.

A reset is raised mid-load to show that recovery to fetch works from a tail state, not only from power-up.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MEMRD  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MEMWR  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } ctrl_state_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_TARGET = 2'b01,
        PCS_JUMP   = 2'b10
    } pc_src_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic       reg_wr;
        logic       reg_dst;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic [1:0] pc_src;
    } ctrl_word_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
#(
    parameter int                OPC_W     = 6,
    parameter logic [OPC_W-1:0]  OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0]  OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0]  OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0]  OPC_BRAN  = 6'b000100,
    parameter logic [OPC_W-1:0]  OPC_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_state_e      state
);

    ctrl_state_e state_q;
    ctrl_state_e state_d;

    // next-state selection; opcode consulted only at the two dispatch points
    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_STORE)
                    state_d = ST_ADDR;
                else if (opcode == OPC_RTYPE)
                    state_d = ST_EXEC;
                else if (opcode == OPC_BRAN)
                    state_d = ST_BRANCH;
                else if (opcode == OPC_JUMP)
                    state_d = ST_JUMP;
                else
                    state_d = ST_FETCH;
            end
            ST_ADDR:   state_d = (opcode == OPC_LOAD) ? ST_MEMRD : ST_MEMWR;
            ST_MEMRD:  state_d = ST_LDWB;
            ST_EXEC:   state_d = ST_RWB;
            ST_LDWB,
            ST_MEMWR,
            ST_RWB,
            ST_BRANCH,
            ST_JUMP:   state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R1: reset lands in fetch
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> state_q == ST_FETCH);

    // R2: fetch always proceeds to decode
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH |=> state_q == ST_DECODE);

    // R4: memory read is followed by load write-back
    assert_memrd_to_ldwb_R4: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MEMRD |=> state_q == ST_LDWB);

    // R6: execute is followed by register write-back
    assert_exec_to_rwb_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EXEC |=> state_q == ST_RWB);

    // R7, R8: branch and jump finish in one state
    assert_short_tail_R7_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRANCH || state_q == ST_JUMP) |=> state_q == ST_FETCH);

    // R9: unlisted opcode in decode returns to fetch
    assert_unknown_opc_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && opcode != OPC_LOAD && opcode != OPC_STORE &&
         opcode != OPC_RTYPE && opcode != OPC_BRAN && opcode != OPC_JUMP)
        |=> state_q == ST_FETCH);

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e state,
    output ctrl_word_t  ctl
);

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b11;
                ctl.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
                ctl.alu_op    = ALU_ADD;
            end
            ST_MEMRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            ST_MEMWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b00;
                ctl.alu_op    = ALU_FUNCT;
            end
            ST_RWB: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            ST_BRANCH: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_src     = PCS_TARGET;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int                OPC_W     = 6,
    parameter logic [OPC_W-1:0]  OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0]  OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0]  OPC_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0]  OPC_BRAN  = 6'b000100,
    parameter logic [OPC_W-1:0]  OPC_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             mem_to_reg,
    output logic             reg_wr,
    output logic             reg_dst,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic [1:0]       pc_src
);

    ctrl_state_e state;
    ctrl_word_t  ctl;

    mc_ctrl_next #(
        .OPC_W     (OPC_W),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_RTYPE (OPC_RTYPE),
        .OPC_BRAN  (OPC_BRAN),
        .OPC_JUMP  (OPC_JUMP)
    ) u_next (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .state  (state)
    );

    mc_ctrl_decode u_dec (
        .state (state),
        .ctl   (ctl)
    );

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_sel   = ctl.addr_sel;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign mem_to_reg = ctl.mem_to_reg;
    assign reg_wr     = ctl.reg_wr;
    assign reg_dst    = ctl.reg_dst;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign alu_op     = ctl.alu_op;
    assign pc_src     = ctl.pc_src;

    // R3: decode is free of side effects
    assert_decode_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        state == ST_DECODE |-> !(pc_wr || pc_wr_cond || mem_rd || mem_wr || ir_wr || reg_wr));

    // R11: exclusive write strobes
    assert_write_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr, reg_wr, pc_wr | pc_wr_cond}));

    // R11: no simultaneous memory read and write
    assert_mem_rw_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R11: reserved ALU class never driven
    assert_alu_class_R11: assert property (@(posedge clk) disable iff (rst)
        alu_op != 2'b11);

    // R5: a memory write is followed by fetch
    assert_store_ends_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b111111;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       mem_to_reg, reg_wr, reg_dst, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mc_ctrl_fsm u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .mem_to_reg(mem_to_reg), .reg_wr(reg_wr), .reg_dst(reg_dst),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src)
    );

    localparam logic [5:0] C_LD = 6'b100011;
    localparam logic [5:0] C_ST = 6'b101011;
    localparam logic [5:0] C_RT = 6'b000000;
    localparam logic [5:0] C_BR = 6'b000100;
    localparam logic [5:0] C_JP = 6'b000010;
    localparam logic [5:0] C_XX = 6'b111111;

    // vector order: pcw pcc ad mr mw irw m2r rw rd asel bsel(2) op(2) src(2)
    function automatic logic [15:0] mk(input logic pcw, pcc, ad, mr, mw, irw,
                                       input logic m2r, rw, rd, asel,
                                       input logic [1:0] bsel, op, src);
        return {pcw, pcc, ad, mr, mw, irw, m2r, rw, rd, asel, bsel, op, src};
    endfunction

    function automatic logic [15:0] v_fetch();  return mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_decode(); return mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_addr();   return mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_memrd();  return mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_ldwb();   return mk(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_memwr();  return mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_exec();   return mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00); endfunction
    function automatic logic [15:0] v_rwb();    return mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00); endfunction
    function automatic logic [15:0] v_branch(); return mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01); endfunction
    function automatic logic [15:0] v_jump();   return mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10); endfunction

    function automatic logic [15:0] outs();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr,
                mem_to_reg, reg_wr, reg_dst, alu_a_sel, alu_b_sel, alu_op, pc_src};
    endfunction

    task automatic chk(input logic [15:0] exp, input string req, input string what);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, outs(), exp);
        end
    endtask

    // reference model: expected per-cycle vectors queued for one instruction
    task automatic run_instr(input logic [5:0] opc, input string req);
        logic [15:0] q[$];
        string       tg[$];
        q.push_back(v_fetch());  tg.push_back("R2");
        q.push_back(v_decode()); tg.push_back("R3");
        case (opc)
            C_LD: begin q.push_back(v_addr());   tg.push_back(req);
                        q.push_back(v_memrd());  tg.push_back(req);
                        q.push_back(v_ldwb());   tg.push_back(req); end
            C_ST: begin q.push_back(v_addr());   tg.push_back(req);
                        q.push_back(v_memwr());  tg.push_back(req); end
            C_RT: begin q.push_back(v_exec());   tg.push_back(req);
                        q.push_back(v_rwb());    tg.push_back(req); end
            C_BR: begin q.push_back(v_branch()); tg.push_back(req); end
            C_JP: begin q.push_back(v_jump());   tg.push_back(req); end
            default: ;
        endcase
        for (int i = 0; i < q.size(); i++) begin
            // R10: foreign codes whenever the opcode should be ignored
            if (i == 1 || (i == 2 && (opc == C_LD || opc == C_ST)))
                opcode = opc;
            else
                opcode = (i % 2 == 1) ? C_JP : C_BR;
            chk(q[i], (i > 1 || i == 0) ? tg[i] : tg[i],
                $sformatf("%s step %0d", req, i));
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        chk(v_fetch(), "R1", "reset state");
        @(posedge clk);
        @(negedge clk);
        chk(v_fetch(), "R1", "reset held");
        rst = 1'b0;

        run_instr(C_LD, "R4");
        run_instr(C_ST, "R5");
        run_instr(C_RT, "R6");
        run_instr(C_BR, "R7");
        run_instr(C_JP, "R8");
        run_instr(C_XX, "R9");
        run_instr(6'b000001, "R9");
        run_instr(C_RT, "R10");
        run_instr(C_LD, "R10");

        // R1: reset in the middle of a load
        opcode = C_XX;
        chk(v_fetch(), "R1", "pre mid-reset fetch");
        @(posedge clk); @(negedge clk);
        opcode = C_LD;
        chk(v_decode(), "R3", "mid-reset decode");
        @(posedge clk); @(negedge clk);
        chk(v_addr(), "R4", "mid-reset addr");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(v_fetch(), "R1", "reset from addr");
        rst = 1'b0;

        run_instr(C_ST, "R5");
        opcode = C_XX;
        chk(v_fetch(), "R5", "return after store");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule